// File: doc/BRIEF.md
# Virtual Address Translation Front-End

This block sits in front of a page-table cache and decides, for every memory access, which translation path applies. Paging can be off, in which case the address passes straight through. A hit in one of two fixed direct-map windows gives a flat mapping. An address outside the legal sign-extended range is rejected. Every other address is handed to the page-table cache, and the cache's answer comes back as a 3-bit result code. The block turns that code, or its own address error, into a compact exception cause. It also records the faulting address in the right set of fault registers.

The caller presents one request per cycle with `req_valid`. The cache lookup request `tlb_lookup` is combinational, and the cache must return `tlb_code`, `tlb_pa` and `tlb_perm` within the same cycle. The translated address, the permissions, the fault strobe, the cause and all fault register updates appear together on the clock edge that follows the request.

Top module: `xlat_front`

## Requirements
- R1: After reset, `out_valid`, `fault_stb`, `fault_cause`, `refill_flag`, `out_pa`, `out_perm` and all four fault address registers are zero.
- R2: When a request has `paging_en` low, the next cycle shows `out_pa` = VA[47:0] and `out_perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute), with no fault. `tlb_lookup` stays low.
- R3: With paging on, a window hits when its config bit 0 (kernel, `user_mode`=0) or bit 3 (user, `user_mode`=1) is set for the current mode and config[63:60] equals VA[63:60]. A hit gives `out_pa` = VA[47:0] and permissions 3'b111. Window 0 is checked before window 1.
- R4: With paging on, no window hit and VA[63:47] neither all zeros nor all ones, the access faults with cause 1 (address error) and `tlb_lookup` stays low.
- R5: `tlb_lookup` is high in the cycle of a request exactly when paging is on, no window hits and the address is canonical. A result code of 0 then passes `tlb_pa` and `tlb_perm` to the outputs without a fault.
- R6: Result codes 2 (no match) and 3 (invalid) give cause 2 for a load (`req_acc`=0), 3 for a store (`req_acc`=1) and 4 for a fetch (`req_acc`=2 or 3).
- R7: Result code 4 gives cause 5 (page modify), 6 gives cause 7 (execute inhibit), 5 gives cause 6 (read inhibit), 7 gives cause 8 (privilege) and 1 gives cause 1 (address error).
- R8: On result code 2, the refill bad-address register takes the VA and the refill entry-hi register takes the VA with bits [14:0] cleared. `refill_flag` becomes 1 and stays set, and `badv` and `ehi` are unchanged.
- R9: On any other fault, `ehi` takes the VA with bits [14:0] cleared, and `badv` takes the VA unless `dbg_hold` is high, in which case it keeps its value. The refill registers are unchanged.
- R10: A cycle with `req_valid` low gives `out_valid` and `fault_stb` low on the next cycle and leaves every fault register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2/3 fetch |
| user_mode | input | 1 | 1 = user privilege, 0 = kernel |
| paging_en | input | 1 | Paging enable |
| win0_cfg | input | 64 | Window 0: base in [63:60], kernel enable bit 0, user enable bit 3 |
| win1_cfg | input | 64 | Window 1, same layout |
| dbg_hold | input | 1 | Debug flag that blocks the `badv` update |
| tlb_code | input | 3 | Page-table cache result code |
| tlb_pa | input | 48 | Page-table cache physical address |
| tlb_perm | input | 3 | Page-table cache permissions |
| tlb_lookup | output | 1 | Combinational lookup request to the cache |
| out_valid | output | 1 | Result valid |
| out_pa | output | 48 | Physical address |
| out_perm | output | 3 | Permissions {x,w,r} |
| fault_stb | output | 1 | Fault in this result |
| fault_cause | output | 4 | Exception cause code |
| refill_flag | output | 1 | Refill-in-progress flag |
| badv | output | 64 | Bad-address register |
| ehi | output | 64 | Entry-hi register |
| rbadv | output | 64 | Refill bad-address register |
| rehi | output | 64 | Refill entry-hi register |

## Verification
`tlb_lookup` is combinational, so the bench checks it 1 ns after it drives a request, in the same cycle. Every registered result, including the fault address registers, is due on the single clock edge after the request. The bench drives on the falling edge, lets one rising edge pass, and compares at the next falling edge before it drives again. Its reference model updates its own register copies at that same edge, so a hold under `dbg_hold` or an idle cycle is checked against the value the register had before.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [2:0] {
        TR_OK       = 3'd0,
        TR_BADADDR  = 3'd1,
        TR_NOMATCH  = 3'd2,
        TR_INVALID  = 3'd3,
        TR_DIRTY    = 3'd4,
        TR_RDINH    = 3'd5,
        TR_EXINH    = 3'd6,
        TR_PRIV     = 3'd7
    } tlb_res_e;

    typedef enum logic [3:0] {
        CS_NONE    = 4'd0,
        CS_ADDR    = 4'd1,
        CS_LD_MISS = 4'd2,
        CS_ST_MISS = 4'd3,
        CS_IF_MISS = 4'd4,
        CS_MODIFY  = 4'd5,
        CS_RD_INH  = 4'd6,
        CS_EX_INH  = 4'd7,
        CS_PRIV    = 4'd8
    } cause_e;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
endpackage

// File: rtl/xlat_window.sv
module xlat_window #(
    parameter int VA_W     = 64,
    parameter int BASE_LSB = 60,
    parameter int KERN_BIT = 0,
    parameter int USER_BIT = 3
) (
    input  logic [VA_W-1:0] cfg,
    input  logic [VA_W-1:0] va,
    input  logic            user_mode,
    output logic            hit
);
    logic mode_ok;
    always_comb begin
        mode_ok = user_mode ? cfg[USER_BIT] : cfg[KERN_BIT];
        hit     = mode_ok && (cfg[VA_W-1:BASE_LSB] == va[VA_W-1:BASE_LSB]);
    end
endmodule

// File: rtl/xlat_fault_enc.sv
module xlat_fault_enc
    import xlat_pkg::*;
(
    input  logic [2:0] code,
    input  logic [1:0] acc,
    output cause_e     cause,
    output logic       is_refill
);
    cause_e miss_cause;
    always_comb begin
        case (acc)
            ACC_LOAD:  miss_cause = CS_LD_MISS;
            ACC_STORE: miss_cause = CS_ST_MISS;
            default:   miss_cause = CS_IF_MISS;
        endcase
        is_refill = (code == TR_NOMATCH);
        case (code)
            TR_OK:                  cause = CS_NONE;
            TR_NOMATCH, TR_INVALID: cause = miss_cause;
            TR_DIRTY:               cause = CS_MODIFY;
            TR_RDINH:               cause = CS_RD_INH;
            TR_EXINH:               cause = CS_EX_INH;
            TR_PRIV:                cause = CS_PRIV;
            default:                cause = CS_ADDR;
        endcase
    end
endmodule

// File: rtl/xlat_front.sv
module xlat_front
    import xlat_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int PA_W       = 48,
    parameter int WIN_LSB    = 60,
    parameter int PAIR_SHIFT = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [63:0]     req_va,
    input  logic [1:0]      req_acc,
    input  logic            user_mode,
    input  logic            paging_en,
    input  logic [63:0]     win0_cfg,
    input  logic [63:0]     win1_cfg,
    input  logic            dbg_hold,
    input  logic [2:0]      tlb_code,
    input  logic [47:0]     tlb_pa,
    input  logic [2:0]      tlb_perm,
    output logic            tlb_lookup,
    output logic            out_valid,
    output logic [47:0]     out_pa,
    output logic [2:0]      out_perm,
    output logic            fault_stb,
    output logic [3:0]      fault_cause,
    output logic            refill_flag,
    output logic [63:0]     badv,
    output logic [63:0]     ehi,
    output logic [63:0]     rbadv,
    output logic [63:0]     rehi
);
    localparam int NUM_WIN = 2;
    localparam int CANON_LSB = PA_W - 1;
    localparam logic [VA_W-1:0] PAIR_MASK = ~((VA_W'(1) << PAIR_SHIFT) - VA_W'(1));

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] pa;
        logic [2:0]      perm;
        logic            fault;
        logic [3:0]      cause;
        logic            refill;
        logic [VA_W-1:0] badv;
        logic [VA_W-1:0] ehi;
        logic [VA_W-1:0] rbadv;
        logic [VA_W-1:0] rehi;
    } state_t;

    state_t st_d, st_q;

    logic [VA_W-1:0] win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;
    assign win_cfg[0] = win0_cfg;
    assign win_cfg[1] = win1_cfg;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        xlat_window #(.VA_W(VA_W), .BASE_LSB(WIN_LSB), .KERN_BIT(0), .USER_BIT(3)) u_win (
            .cfg(win_cfg[w]), .va(req_va), .user_mode(user_mode), .hit(win_hit[w])
        );
    end

    cause_e enc_cause;
    logic   enc_refill;
    xlat_fault_enc u_enc (
        .code(tlb_code), .acc(req_acc), .cause(enc_cause), .is_refill(enc_refill)
    );

    logic canon_ok;
    logic lookup_d;
    logic [VA_W-1:0] va_pair;

    always_comb begin
        canon_ok = (&req_va[VA_W-1:CANON_LSB]) || !(|req_va[VA_W-1:CANON_LSB]);
        va_pair  = req_va & PAIR_MASK;
        st_d        = st_q;
        st_d.valid  = req_valid;
        st_d.pa     = '0;
        st_d.perm   = '0;
        st_d.fault  = 1'b0;
        st_d.cause  = CS_NONE;
        lookup_d    = 1'b0;
        if (req_valid) begin
            if (!paging_en || (|win_hit)) begin
                st_d.pa   = req_va[PA_W-1:0];
                st_d.perm = 3'b111;
            end else if (!canon_ok) begin
                st_d.fault = 1'b1;
                st_d.cause = CS_ADDR;
                st_d.ehi   = va_pair;
                if (!dbg_hold) st_d.badv = req_va;
            end else begin
                lookup_d = 1'b1;
                if (tlb_code == TR_OK) begin
                    st_d.pa   = tlb_pa;
                    st_d.perm = tlb_perm;
                end else begin
                    st_d.fault = 1'b1;
                    st_d.cause = enc_cause;
                    if (enc_refill) begin
                        st_d.refill = 1'b1;
                        st_d.rbadv  = req_va;
                        st_d.rehi   = va_pair;
                    end else begin
                        st_d.ehi = va_pair;
                        if (!dbg_hold) st_d.badv = req_va;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tlb_lookup  = lookup_d;
    assign out_valid   = st_q.valid;
    assign out_pa      = st_q.pa;
    assign out_perm    = st_q.perm;
    assign fault_stb   = st_q.fault;
    assign fault_cause = st_q.cause;
    assign refill_flag = st_q.refill;
    assign badv        = st_q.badv;
    assign ehi         = st_q.ehi;
    assign rbadv       = st_q.rbadv;
    assign rehi        = st_q.rehi;
endmodule

// File: rtl/xlat_front_chk.sv
module xlat_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_va,
    input logic        paging_en,
    input logic        dbg_hold,
    input logic [2:0]  tlb_code,
    input logic        tlb_lookup,
    input logic        out_valid,
    input logic [47:0] out_pa,
    input logic [2:0]  out_perm,
    input logic        fault_stb,
    input logic [3:0]  fault_cause,
    input logic        refill_flag,
    input logic [63:0] badv,
    input logic [63:0] ehi,
    input logic [63:0] rbadv,
    input logic [63:0] rehi
);
    assert_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !paging_en) |=> (out_valid && !fault_stb && out_perm == 3'b111
                                        && out_pa == $past(req_va[47:0])));

    assert_lookup_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_lookup |-> (req_valid && paging_en));

    assert_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && tlb_code == 3'd2) |=> (refill_flag && fault_stb
                                              && rbadv == $past(req_va) && $stable(badv)));

    assert_refill_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refill_flag |=> refill_flag);

    assert_dbg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && tlb_code > 3'd2 && dbg_hold) |=> ($stable(badv) && $stable(rbadv)));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !fault_stb && $stable(badv) && $stable(ehi)
                        && $stable(rbadv) && $stable(rehi)));

    assert_cause_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stb == (fault_cause != 4'd0));
endmodule

bind xlat_front xlat_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .paging_en(paging_en), .dbg_hold(dbg_hold), .tlb_code(tlb_code),
    .tlb_lookup(tlb_lookup), .out_valid(out_valid), .out_pa(out_pa),
    .out_perm(out_perm), .fault_stb(fault_stb), .fault_cause(fault_cause),
    .refill_flag(refill_flag), .badv(badv), .ehi(ehi), .rbadv(rbadv), .rehi(rehi)
);

// File: tb/xlat_front_test.sv
module xlat_front_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        user_mode = 1'b0;
    logic        paging_en = 1'b0;
    logic [63:0] win0_cfg = '0;
    logic [63:0] win1_cfg = '0;
    logic        dbg_hold = 1'b0;
    logic [2:0]  tlb_code = '0;
    logic [47:0] tlb_pa = '0;
    logic [2:0]  tlb_perm = '0;
    logic        tlb_lookup, out_valid, fault_stb, refill_flag;
    logic [47:0] out_pa;
    logic [2:0]  out_perm;
    logic [3:0]  fault_cause;
    logic [63:0] badv, ehi, rbadv, rehi;

    xlat_front uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
        .user_mode(user_mode), .paging_en(paging_en), .win0_cfg(win0_cfg), .win1_cfg(win1_cfg),
        .dbg_hold(dbg_hold), .tlb_code(tlb_code), .tlb_pa(tlb_pa), .tlb_perm(tlb_perm),
        .tlb_lookup(tlb_lookup), .out_valid(out_valid), .out_pa(out_pa), .out_perm(out_perm),
        .fault_stb(fault_stb), .fault_cause(fault_cause), .refill_flag(refill_flag),
        .badv(badv), .ehi(ehi), .rbadv(rbadv), .rehi(rehi)
    );

    always #2 clk = ~clk;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    logic [63:0] m_badv = '0, m_ehi = '0, m_rbadv = '0, m_rehi = '0;
    logic        m_refill = 1'b0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit win_hit(input logic [63:0] cfg, input logic [63:0] va, input logic um);
        return (um ? cfg[3] : cfg[0]) && (cfg[63:60] == va[63:60]);
    endfunction

    function automatic logic [3:0] exp_cause(input logic [2:0] code, input logic [1:0] acc);
        case (code)
            3'd0: return 4'd0;
            3'd2, 3'd3: return (acc == 2'd0) ? 4'd2 : (acc == 2'd1) ? 4'd3 : 4'd4;
            3'd4: return 4'd5;
            3'd5: return 4'd6;
            3'd6: return 4'd7;
            3'd7: return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    task automatic step(input bit v, input logic [63:0] va, input logic [1:0] acc, input bit um,
                        input bit pg, input logic [63:0] w0, input logic [63:0] w1, input bit dbg,
                        input logic [2:0] code, input logic [47:0] tpa, input logic [2:0] tperm);
        string tag;
        bit hit, canon, look, e_fault;
        logic [47:0] e_pa;
        logic [2:0]  e_perm;
        logic [3:0]  e_cause;
        logic [63:0] pair;
        req_valid = v; req_va = va; req_acc = acc; user_mode = um; paging_en = pg;
        win0_cfg = w0; win1_cfg = w1; dbg_hold = dbg; tlb_code = code; tlb_pa = tpa; tlb_perm = tperm;
        hit   = win_hit(w0, va, um) || win_hit(w1, va, um);
        canon = (va[63:47] == '0) || (va[63:47] == '1);
        look  = v && pg && !hit && canon;
        pair  = va & ~64'h7FFF;
        e_pa = '0; e_perm = '0; e_fault = 0; e_cause = 4'd0;
        if (!v) tag = "R10";
        else if (!pg) begin tag = "R2"; e_pa = va[47:0]; e_perm = 3'b111; end
        else if (hit) begin tag = "R3"; e_pa = va[47:0]; e_perm = 3'b111; end
        else if (!canon) begin
            tag = "R4"; e_fault = 1; e_cause = 4'd1; m_ehi = pair;
            if (!dbg) m_badv = va;
        end else if (code == 3'd0) begin tag = "R5"; e_pa = tpa; e_perm = tperm; end
        else begin
            e_fault = 1; e_cause = exp_cause(code, acc);
            if (code == 3'd2) begin
                tag = "R8"; m_refill = 1; m_rbadv = va; m_rehi = pair;
            end else begin
                tag = (code == 3'd3) ? "R6" : (dbg ? "R9" : "R7");
                m_ehi = pair;
                if (!dbg) m_badv = va;
            end
        end
        #1;
        chk("R5", "tlb_lookup", 64'(tlb_lookup), 64'(look));
        @(posedge clk);
        @(negedge clk);
        chk(tag, "out_valid", 64'(out_valid), 64'(v));
        chk(tag, "out_pa", 64'(out_pa), 64'(e_pa));
        chk(tag, "out_perm", 64'(out_perm), 64'(e_perm));
        chk(tag, "fault_stb", 64'(fault_stb), 64'(e_fault));
        chk(tag, "fault_cause", 64'(fault_cause), 64'(e_cause));
        chk(tag, "refill_flag", 64'(refill_flag), 64'(m_refill));
        chk(tag, "badv", badv, m_badv);
        chk(tag, "ehi", ehi, m_ehi);
        chk(tag, "rbadv", rbadv, m_rbadv);
        chk(tag, "rehi", rehi, m_rehi);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] va, w0, w1;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", 64'(out_valid), 0);
        chk("R1", "fault_stb", 64'(fault_stb), 0);
        chk("R1", "fault_cause", 64'(fault_cause), 0);
        chk("R1", "refill_flag", 64'(refill_flag), 0);
        chk("R1", "out_pa", 64'(out_pa), 0);
        chk("R1", "out_perm", 64'(out_perm), 0);
        chk("R1", "badv", badv, 0);
        chk("R1", "rehi", rehi, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: paging off, non-canonical VA still passes
        step(1, 64'hABCD_1234_5678_9ABC, 0, 0, 0, 0, 0, 0, 3'd2, 0, 0);
        // R3: window 0 wins over window 1, user enable bit 3
        step(1, 64'h9000_0000_1234_5000, 2, 1, 1, 64'h9000_0000_0000_0008, 64'h9000_0000_0000_0008, 0, 3'd2, 0, 0);
        // R3: kernel bit only, user mode misses -> non canonical R4
        step(1, 64'h9000_0000_1234_5000, 0, 1, 1, 64'h9000_0000_0000_0001, 0, 0, 3'd0, 0, 0);
        // R3: window 1 only hit
        step(1, 64'h8000_0000_0000_4444, 0, 0, 1, 64'h9000_0000_0000_0001, 64'h8000_0000_0000_0001, 0, 3'd2, 0, 0);
        // R5: canonical high address, TLB match
        step(1, 64'hFFFF_8000_0000_7ABC, 1, 0, 1, 0, 0, 0, 3'd0, 48'h1234_5678_9ABC, 3'b011);
        // R8: refill miss on store
        step(1, 64'h0000_1234_5678_FFFF, 1, 0, 1, 0, 0, 0, 3'd2, 0, 0);
        // R6: invalid on fetch (acc 3 counts as fetch)
        step(1, 64'h0000_0000_0001_8001, 3, 0, 1, 0, 0, 0, 3'd3, 0, 0);
        // R7: dirty
        step(1, 64'h0000_0000_0002_8002, 1, 0, 1, 0, 0, 0, 3'd4, 0, 0);
        // R9: privilege fault with debug hold keeps badv
        step(1, 64'h0000_0000_0003_8003, 0, 1, 1, 0, 0, 1, 3'd7, 0, 0);
        // R10: idle cycle
        step(0, 64'h0000_0000_0004_0000, 0, 0, 1, 0, 0, 0, 3'd2, 0, 0);
        // R7: bad address code from cache
        step(1, 64'h0000_0000_0005_0000, 0, 0, 1, 0, 0, 0, 3'd1, 0, 0);
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 4)
                0: va = {17'h0, 47'($urandom) ^ {15'($urandom), 32'h0}};
                1: va = {17'h1FFFF, 47'({$urandom, $urandom})};
                2: va = {$urandom, $urandom};
                default: va = {4'($urandom % 3 + 7), 60'({$urandom, $urandom})};
            endcase
            w0 = {4'($urandom % 3 + 7), 52'h0, 8'($urandom)};
            w1 = {4'($urandom % 3 + 7), 52'h0, 8'($urandom)};
            step(($urandom % 10) != 0, va, 2'($urandom), 1'($urandom), ($urandom % 8) != 0,
                 w0, w1, ($urandom % 4) == 0, 3'($urandom),
                 48'({$urandom, $urandom}), 3'($urandom));
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule